// File: doc/BRIEF.md
# Bus Read/Write Strobe Handshake Controller

This block sits between a bus master and a slow device. It turns the master's read or write strobe into a device-side strobe and watches the device's acknowledge. It also drives the enable of a data transceiver and returns a transfer acknowledge to the master. All signals are sampled on one clock. Every output is a register, so each step of the handshake takes at least one clock edge.

The read cycle is built from four small register equations. One of them is an internal state-coding bit that copies the read strobe. The other three are:

- the transceiver enable, set from the device acknowledge gated by that bit;
- the device strobe, set from the enable OR the bit;
- the bus acknowledge, set from the enable.

This fixes the order of events with no large state machine. The write cycle is a short sequencer. The enable is raised before the device strobe, and the enable is dropped again before the bus acknowledge. A monitor compares each input transition with what the current state permits. It raises a sticky protocol-error flag when a transition is not permitted. Only reset clears that flag.

Top module: `hs_rdwr_ctrl`

## Requirements
- R1: After reset, dev_strb_o, xcvr_en_o, bus_ack_o and proto_err_o are 0. These outputs stay 0 while neither strobe nor dev_ack_i is active.
- R2: Read start. If rd_strb_i is first sampled 1 at edge k, dev_strb_o becomes 1 at edge k+1. xcvr_en_o and bus_ack_o stay 0 until the device acknowledges.
- R3: In a read, xcvr_en_o becomes 1 at the first edge that samples dev_ack_i at 1. dev_strb_o stays 1.
- R4: In a read, bus_ack_o becomes 1 one edge after xcvr_en_o. It stays 1 while rd_strb_i is held.
- R5: Read release. If rd_strb_i is first sampled 0 at edge k, xcvr_en_o falls at edge k+1. bus_ack_o and dev_strb_o both fall at edge k+2. The device then drops dev_ack_i.
- R6: Write start. If wr_strb_i is first sampled 1 at edge k, xcvr_en_o becomes 1 at edge k. dev_strb_o becomes 1 at edge k+1.
- R7: In a write, the edge that first samples dev_ack_i at 1 drops xcvr_en_o. bus_ack_o becomes 1 at the next edge, and dev_strb_o stays 1.
- R8: Write release. The edge that first samples wr_strb_i at 0 drops dev_strb_o while bus_ack_o stays 1. The edge that then samples dev_ack_i at 0 drops bus_ack_o.
- R9: proto_err_o is set at the edge that samples a transition the current state does not permit. Examples are an acknowledge at idle, or a strobe released before bus_ack_o. A correct handshake never sets it. Once set, it stays 1 until reset.
- R10: rd_strb_i and wr_strb_i sampled at 1 at the same edge set proto_err_o at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strb_i | input | 1 | Bus read strobe, active high |
| wr_strb_i | input | 1 | Bus write strobe, active high |
| dev_ack_i | input | 1 | Device acknowledge, active high |
| dev_strb_o | output | 1 | Device strobe |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Transfer acknowledge to the bus |
| proto_err_o | output | 1 | Sticky protocol-violation flag |

## Verification
Reads and writes are run with a device-acknowledge latency of zero to five cycles and a strobe hold of zero to five cycles. Directed cases are mixed with a seeded random sequence of transactions. Latency zero shows whether the enable truly waits for the sampled acknowledge. Longer latencies show whether the strobe and enable hold steady while the device is waiting. The random sequence interleaves reads and writes, which shows that neither cycle leaves state behind that upsets the next one.

Four illegal patterns each run after their own reset:

- an acknowledge at idle, which also shows that the flag is sticky;
- a read strobe released early;
- a write strobe released early;
- both strobes raised together.

Each pattern must raise the error flag, and no legal run may raise it.

// File: rtl/hs_pkg.sv
package hs_pkg;
   typedef enum logic [2:0] {
      W_IDLE, W_EN, W_STB, W_DROP, W_ACK, W_REL
   } wr_state_e;

   // outputs one engine wants to drive
   typedef struct packed {
      logic strobe;
      logic xen;
      logic ack;
   } hs_drive_t;

   // which input transitions an engine permits in its present state
   typedef struct packed {
      logic idle;
      logic ack_rise_ok;
      logic ack_fall_ok;
      logic strb_fall_ok;
   } hs_perm_t;
endpackage

// File: rtl/hs_read_eqn.sv
module hs_read_eqn
   import hs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rd_i,
   input  logic      dev_ack_i,
   output hs_drive_t drv_o,
   output hs_perm_t  perm_o
);
   logic csc_q, xen_q, strb_q, ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csc_q  <= 1'b0;
         xen_q  <= 1'b0;
         strb_q <= 1'b0;
         ack_q  <= 1'b0;
      end else begin
         csc_q  <= rd_i;
         xen_q  <= dev_ack_i & csc_q;
         strb_q <= xen_q | csc_q;
         ack_q  <= xen_q;
      end
   end

   assign drv_o = '{strobe: strb_q, xen: xen_q, ack: ack_q};

   always_comb begin
      perm_o.idle         = !csc_q && !strb_q && !xen_q && !ack_q;
      perm_o.ack_rise_ok  = csc_q && strb_q && !xen_q && !ack_q;
      perm_o.ack_fall_ok  = !csc_q && !strb_q && !xen_q;
      perm_o.strb_fall_ok = csc_q && ack_q;
   end

   // R2: the enable never rises without the device strobe up
   p_strobe_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xen_q) |-> strb_q);
   // R3: enable rises only after a sampled device acknowledge
   p_xen_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xen_q) |-> $past(dev_ack_i));
   // R4: bus acknowledge follows the enable by one edge
   p_ack_after_xen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> $past(xen_q) && strb_q);
   // R5: device strobe drops only once the enable is already low
   p_release_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb_q) |-> !xen_q && !ack_q);
endmodule

// File: rtl/hs_write_seq.sv
module hs_write_seq
   import hs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_i,
   input  logic      dev_ack_i,
   output hs_drive_t drv_o,
   output hs_perm_t  perm_o
);
   wr_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         W_IDLE:  if (wr_i) st_d = W_EN;
         W_EN:    st_d = W_STB;
         W_STB:   if (dev_ack_i) st_d = W_DROP;
         W_DROP:  st_d = W_ACK;
         W_ACK:   if (!wr_i) st_d = W_REL;
         W_REL:   if (!dev_ack_i) st_d = W_IDLE;
         default: st_d = W_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= W_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      drv_o.xen    = (st_q == W_EN) || (st_q == W_STB);
      drv_o.strobe = (st_q == W_STB) || (st_q == W_DROP) || (st_q == W_ACK);
      drv_o.ack    = (st_q == W_ACK) || (st_q == W_REL);
      perm_o.idle         = (st_q == W_IDLE);
      perm_o.ack_rise_ok  = (st_q == W_STB);
      perm_o.ack_fall_ok  = (st_q == W_REL);
      perm_o.strb_fall_ok = (st_q == W_ACK);
   end

   // R6: the device strobe rises while the enable is already up
   p_wr_en_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_o.strobe) |-> drv_o.xen && $past(drv_o.xen));
   // R7: bus acknowledge rises only after the enable has dropped
   p_wr_ack_after_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_o.ack) |-> !drv_o.xen && drv_o.strobe);
   // R8: bus acknowledge drops only after the device strobe is gone
   p_wr_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_o.ack) |-> !drv_o.strobe && !dev_ack_i);
endmodule

// File: rtl/hs_proto_mon.sv
module hs_proto_mon
   import hs_pkg::*;
#(
   parameter bit WRITE_SUPPORT = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     rd_i,
   input  logic     wr_i,
   input  logic     dev_ack_i,
   input  hs_perm_t rd_perm_i,
   input  hs_perm_t wr_perm_i,
   output logic     err_o
);
   logic rd_q, wr_q, ack_q, err_q, viol;
   logic rd_rise, rd_fall, wr_rise, wr_fall, ack_rise, ack_fall, all_idle;

   always_comb begin
      rd_rise  = rd_i & ~rd_q;
      rd_fall  = ~rd_i & rd_q;
      wr_rise  = wr_i & ~wr_q;
      wr_fall  = ~wr_i & wr_q;
      ack_rise = dev_ack_i & ~ack_q;
      ack_fall = ~dev_ack_i & ack_q;
      all_idle = rd_perm_i.idle && wr_perm_i.idle && !dev_ack_i;
      viol = (rd_i && wr_i)
          || (rd_rise && !all_idle)
          || (wr_rise && (!all_idle || !WRITE_SUPPORT))
          || (rd_fall && !rd_perm_i.strb_fall_ok)
          || (wr_fall && !wr_perm_i.strb_fall_ok)
          || (ack_rise && !(rd_perm_i.ack_rise_ok || wr_perm_i.ack_rise_ok))
          || (ack_fall && !((rd_perm_i.ack_fall_ok && wr_perm_i.idle)
                            || wr_perm_i.ack_fall_ok));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         wr_q  <= 1'b0;
         ack_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         rd_q  <= rd_i;
         wr_q  <= wr_i;
         ack_q <= dev_ack_i;
         err_q <= err_q | viol;
      end
   end

   assign err_o = err_q;

   // R9: once raised the flag holds until reset
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
   // R10: both strobes together always end in an error
   p_both_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && wr_i) |=> err_q);
endmodule

// File: rtl/hs_rdwr_ctrl.sv
module hs_rdwr_ctrl
   import hs_pkg::*;
#(
   parameter bit WRITE_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_strb_i,
   input  logic wr_strb_i,
   input  logic dev_ack_i,
   output logic dev_strb_o,
   output logic xcvr_en_o,
   output logic bus_ack_o,
   output logic proto_err_o
);
   hs_drive_t rd_drv, wr_drv;
   hs_perm_t  rd_perm, wr_perm;

   hs_read_eqn u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_i      (rd_strb_i),
      .dev_ack_i (dev_ack_i),
      .drv_o     (rd_drv),
      .perm_o    (rd_perm)
   );

   generate
      if (WRITE_SUPPORT) begin : g_write
         hs_write_seq u_write (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_strb_i),
            .dev_ack_i (dev_ack_i),
            .drv_o     (wr_drv),
            .perm_o    (wr_perm)
         );
      end else begin : g_no_write
         assign wr_drv  = '0;
         assign wr_perm = '{idle: 1'b1, ack_rise_ok: 1'b0,
                            ack_fall_ok: 1'b0, strb_fall_ok: 1'b0};
      end
   endgenerate

   hs_proto_mon #(.WRITE_SUPPORT(WRITE_SUPPORT)) u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_i      (rd_strb_i),
      .wr_i      (wr_strb_i),
      .dev_ack_i (dev_ack_i),
      .rd_perm_i (rd_perm),
      .wr_perm_i (wr_perm),
      .err_o     (proto_err_o)
   );

   assign dev_strb_o = rd_drv.strobe | wr_drv.strobe;
   assign xcvr_en_o  = rd_drv.xen    | wr_drv.xen;
   assign bus_ack_o  = rd_drv.ack    | wr_drv.ack;

   // R1: quiet inputs with quiet outputs keep the outputs quiet
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_strb_i && !wr_strb_i && !dev_ack_i && $past(!rd_strb_i && !wr_strb_i)
       && !dev_strb_o && !xcvr_en_o && !bus_ack_o)
      |=> (!dev_strb_o && !xcvr_en_o && !bus_ack_o));
endmodule

// File: tb/hs_rdwr_ctrl_bench.sv
module hs_rdwr_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n, rd, wr, dack;
   logic ds, xen, back, err;
   int   n_total = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   hs_rdwr_ctrl u_hs_rdwr_ctrl (
      .clk(clk), .rst_n(rst_n), .rd_strb_i(rd), .wr_strb_i(wr), .dev_ack_i(dack),
      .dev_strb_o(ds), .xcvr_en_o(xen), .bus_ack_o(back), .proto_err_o(err)
   );

   // expected {strobe, enable, bus ack} for each named handshake step
   typedef enum {S_IDLE, S_RD_WAIT, S_RD_STB, S_RD_EN, S_RD_ACK, S_RD_EN_OFF,
                 S_WR_EN, S_WR_STB, S_WR_DROP, S_WR_ACK, S_WR_REL} step_e;
   function automatic logic [2:0] exp_out(step_e s);
      case (s)
         S_RD_WAIT:   return 3'b000;
         S_RD_STB:    return 3'b100;
         S_RD_EN:     return 3'b110;
         S_RD_ACK:    return 3'b111;
         S_RD_EN_OFF: return 3'b101;
         S_WR_EN:     return 3'b010;
         S_WR_STB:    return 3'b110;
         S_WR_DROP:   return 3'b100;
         S_WR_ACK:    return 3'b101;
         S_WR_REL:    return 3'b001;
         default:     return 3'b000;
      endcase
   endfunction

   task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: outputs act=%b exp=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_step(string req, step_e s);
      chk(req, {ds, xen, back}, exp_out(s));
   endtask

   task automatic chk_err(string req, logic exp);
      chk(req, {2'b00, err}, {2'b00, exp});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rd = 1'b0; wr = 1'b0; dack = 1'b0;
      repeat (2) @(negedge clk);
      chk_step("R1 reset outputs", S_IDLE);
      chk_err("R1 reset error flag", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_read(int dly, int hold);
      rd = 1'b1;
      @(negedge clk); chk_step("R2 read first edge", S_RD_WAIT);
      @(negedge clk); chk_step("R2 read strobe", S_RD_STB);
      for (int i = 0; i < dly; i++) begin
         @(negedge clk); chk_step("R2 read wait ack", S_RD_STB);
      end
      dack = 1'b1;
      @(negedge clk); chk_step("R3 read enable", S_RD_EN);
      @(negedge clk); chk_step("R4 read bus ack", S_RD_ACK);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk); chk_step("R4 read hold", S_RD_ACK);
      end
      rd = 1'b0;
      @(negedge clk); chk_step("R5 release edge k", S_RD_ACK);
      @(negedge clk); chk_step("R5 release enable off", S_RD_EN_OFF);
      @(negedge clk); chk_step("R5 release all off", S_IDLE);
      dack = 1'b0;
      @(negedge clk); chk_step("R1 idle after read", S_IDLE);
      chk_err("R9 no error on legal read", 1'b0);
   endtask

   task automatic do_write(int dly, int hold);
      wr = 1'b1;
      @(negedge clk); chk_step("R6 write enable", S_WR_EN);
      @(negedge clk); chk_step("R6 write strobe", S_WR_STB);
      for (int i = 0; i < dly; i++) begin
         @(negedge clk); chk_step("R6 write wait ack", S_WR_STB);
      end
      dack = 1'b1;
      @(negedge clk); chk_step("R7 write enable drop", S_WR_DROP);
      @(negedge clk); chk_step("R7 write bus ack", S_WR_ACK);
      for (int i = 0; i < hold; i++) begin
         @(negedge clk); chk_step("R7 write hold", S_WR_ACK);
      end
      wr = 1'b0;
      @(negedge clk); chk_step("R8 write strobe off", S_WR_REL);
      for (int i = 0; i < dly; i++) begin
         @(negedge clk); chk_step("R8 write ack held", S_WR_REL);
      end
      dack = 1'b0;
      @(negedge clk); chk_step("R8 write release", S_IDLE);
      chk_err("R9 no error on legal write", 1'b0);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL watchdog: act=running exp=finished");
         report();
      end
   end

   initial begin
      void'($urandom(32'h1d5e_0a17));
      rst_n = 1'b0; rd = 1'b0; wr = 1'b0; dack = 1'b0;
      do_reset();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); chk_step("R1 idle quiet", S_IDLE);
      end
      // directed corners
      do_read(0, 0);
      do_read(3, 2);
      do_write(0, 0);
      do_write(4, 3);
      // seeded random mix
      for (int t = 0; t < 40; t++) begin
         int gap = $urandom_range(1, 3);
         if ($urandom_range(0, 1) == 0) do_read($urandom_range(0, 5), $urandom_range(0, 5));
         else                           do_write($urandom_range(0, 5), $urandom_range(0, 5));
         repeat (gap) @(negedge clk);
      end
      chk_err("R9 no error after random run", 1'b0);

      // acknowledge at idle, then stickiness
      do_reset();
      dack = 1'b1;
      @(negedge clk); chk_err("R9 ack at idle", 1'b1);
      dack = 1'b0;
      repeat (3) @(negedge clk);
      chk_err("R9 flag sticky", 1'b1);

      // read strobe released before bus ack
      do_reset();
      rd = 1'b1;
      repeat (2) @(negedge clk);
      rd = 1'b0;
      @(negedge clk); chk_err("R9 early read release", 1'b1);

      // write strobe released before bus ack
      do_reset();
      wr = 1'b1;
      repeat (2) @(negedge clk);
      wr = 1'b0;
      @(negedge clk); chk_err("R9 early write release", 1'b1);

      // both strobes at once
      do_reset();
      rd = 1'b1; wr = 1'b1;
      @(negedge clk); chk_err("R10 both strobes", 1'b1);
      rd = 1'b0; wr = 1'b0;

      do_reset();
      done = 1'b1;
      report();
   end
endmodule